// File: doc/BRIEF.md
# Serial Channel Register Front-End

This block is the register side of one asynchronous serial channel, as a processor sees it. A byte-wide bus with a chip select, a five-bit register offset and separate read and write strobes reaches the channel's configuration, command, status, data and interrupt registers. The bit-level shifters and the baud generator sit outside the block. They connect through two simple handshakes. The receive side offers a byte with a one-cycle valid pulse. The transmit side takes the held byte in any cycle where it signals that it is free.

Two mode registers share one offset. An internal pointer picks which of them a write reaches, and a command can return that pointer to the first register. At several offsets a read and a write reach different registers. A four-entry receive queue feeds the receiver-ready status and the interrupt logic. During an interrupt acknowledge the block places its vector byte on the read bus.

Top module: `sio_regfront`

## Requirements
- R1: Offset 2 reads the status byte and writes the clock-select byte, which is driven on `clkSel`. Offset 8 reads and writes the auxiliary control byte, which is driven on `auxCtrl`. `rdata` is 0 when no read or acknowledge is active.
- R2: Writes to offset 0 go to mode register A first and to mode register B after that. Later writes keep going to B until a command with upper nibble 1 resets the pointer. A read of offset 0 returns the register the pointer selects.
- R3: Bits [1:0] of mode register A select the character width: 0→5, 1→6, 2→7, 3→8 bits. A received byte is stored with every bit above that width cleared.
- R4: In a command byte (offset 4), bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. Disable wins over enable. 0x05 enables both. Both are disabled after reset.
- R5: While the receiver is disabled, incoming bytes are ignored.
- R6: Status bits: bit0 is receiver ready (queue not empty), bit1 is queue full, bit2 is transmitter ready (enabled and holding register empty), bit4 is overrun. All other bits read 0.
- R7: The receive queue holds up to 4 bytes. A read of offset 6 returns the oldest byte and removes it.
- R8: A byte that arrives while the queue is full is dropped and sets the sticky overrun bit. A command with upper nibble 2 empties the queue, clears overrun and disables the receiver.
- R9: A write to offset 6 while the transmitter is ready loads the holding register. `txValid` then stays high with a stable `txByte` until a cycle with `txFree` high. A write while not ready is ignored. A command with upper nibble 3 drops any held byte and disables the transmitter.
- R10: Interrupt status (read at offset 10) has bit0 = transmitter ready and bit1 = receiver ready. Writing offset 10 sets the mask, which is 0 after reset. `irq` is high when any status bit has its mask bit set.
- R11: Offset 24 reads and writes the vector byte, which is 0x0F after reset. While `iack` is high, `rdata` carries the vector and bus accesses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request, active high |
| rxByte | input | 8 | Byte from the deserializer |
| rxValid | input | 1 | One-cycle pulse: rxByte is valid |
| txByte | output | 8 | Byte for the serializer |
| txValid | output | 1 | Holding register is full |
| txFree | input | 1 | Serializer takes txByte this cycle |
| clkSel | output | 8 | Clock-select byte |
| auxCtrl | output | 8 | Auxiliary control byte |
| modeA | output | 8 | Mode register A |
| modeB | output | 8 | Mode register B |

## Verification
The bound checker watches several properties on every cycle:
- the queue never holds more than its depth;
- overrun stays set until a receiver-reset command;
- a disabled receiver never changes the queue occupancy;
- an accepted byte raises the occupancy by one;
- a held transmit byte stays stable until it is taken;
- a zero mask keeps `irq` low;
- acknowledge returns the vector.

Only the bench scenarios show the data contents. These are the width masking across all four widths, first-in first-out order, mode-pointer sequencing, offsets whose read and write reach different registers, and the ignored transmit writes.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_MODE = 0;
  localparam int OFF_STAT = 2;
  localparam int OFF_CMD = 4;
  localparam int OFF_DATA = 6;
  localparam int OFF_AUX = 8;
  localparam int OFF_INT = 10;
  localparam int OFF_VEC = 24;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODEA, SEL_MODEB, SEL_STAT, SEL_RX, SEL_AUX, SEL_ISR, SEL_VEC
  } rd_sel_e;

  typedef struct packed {
    logic    wrModeA;
    logic    wrModeB;
    logic    wrClk;
    logic    wrAux;
    logic    wrImr;
    logic    wrVec;
    logic    wrTx;
    logic    popRx;
    logic    rxRst;
    logic    txRst;
    logic    rxEnSet;
    logic    rxEnClr;
    logic    txEnSet;
    logic    txEnClr;
    rd_sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              iack,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output strobe_t           stb
);
  logic modePtr;
  logic ptrRst;
  logic wrHit, rdHit;

  assign wrHit = cs && wr && !iack;
  assign rdHit = cs && rd && !iack;

  always_comb begin
    stb = '0;
    stb.rdSel = SEL_NONE;
    ptrRst = 1'b0;
    if (iack) begin
      stb.rdSel = SEL_VEC;
    end else begin
      if (rdHit) begin
        case (addr)
          ADDR_W'(OFF_MODE): stb.rdSel = modePtr ? SEL_MODEB : SEL_MODEA;
          ADDR_W'(OFF_STAT): stb.rdSel = SEL_STAT;
          ADDR_W'(OFF_DATA): begin stb.rdSel = SEL_RX; stb.popRx = 1'b1; end
          ADDR_W'(OFF_AUX):  stb.rdSel = SEL_AUX;
          ADDR_W'(OFF_INT):  stb.rdSel = SEL_ISR;
          ADDR_W'(OFF_VEC):  stb.rdSel = SEL_VEC;
          default:           stb.rdSel = SEL_NONE;
        endcase
      end
      if (wrHit) begin
        case (addr)
          ADDR_W'(OFF_MODE): begin stb.wrModeA = !modePtr; stb.wrModeB = modePtr; end
          ADDR_W'(OFF_STAT): stb.wrClk = 1'b1;
          ADDR_W'(OFF_CMD): begin
            case (wdata[7:4])
              4'h1:    ptrRst = 1'b1;
              4'h2:    stb.rxRst = 1'b1;
              4'h3:    stb.txRst = 1'b1;
              default: ;
            endcase
            stb.rxEnSet = wdata[0];
            stb.rxEnClr = wdata[1];
            stb.txEnSet = wdata[2];
            stb.txEnClr = wdata[3];
          end
          ADDR_W'(OFF_DATA): stb.wrTx = 1'b1;
          ADDR_W'(OFF_AUX):  stb.wrAux = 1'b1;
          ADDR_W'(OFF_INT):  stb.wrImr = 1'b1;
          ADDR_W'(OFF_VEC):  stb.wrVec = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         modePtr <= 1'b0;
    else if (ptrRst)   modePtr <= 1'b0;
    else if (stb.wrModeA) modePtr <= 1'b1;
  end
endmodule

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int              RX_DEPTH  = 4,
  parameter logic [BYTE_W-1:0] VEC_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  input  logic              txFree,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic              irq,
  output logic [BYTE_W-1:0] clkSel,
  output logic [BYTE_W-1:0] auxCtrl,
  output logic [BYTE_W-1:0] modeA,
  output logic [BYTE_W-1:0] modeB
);
  localparam int CNT_W = $clog2(RX_DEPTH + 1);
  localparam int PTR_W = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;

  logic [BYTE_W-1:0] imr, vecReg, txHold;
  logic              rxEn, txEn, holdFull, overrun;
  logic [BYTE_W-1:0] rxMem [RX_DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  rxCount;
  logic              rxReady, rxFull, txReady, push, doPop, txLoad;
  logic [BYTE_W-1:0] status, isr, widthMask;

  assign rxReady = (rxCount != '0);
  assign rxFull  = (rxCount == CNT_W'(RX_DEPTH));
  assign txReady = txEn && !holdFull;
  assign status  = {3'b000, overrun, 1'b0, txReady, rxFull, rxReady};
  assign isr     = {6'b0, rxReady, txReady};
  assign irq     = |(isr & imr);
  assign push    = rxValid && rxEn && !rxFull;
  assign doPop   = stb.popRx && rxReady;
  assign txLoad  = stb.wrTx && txReady;
  assign widthMask = 8'hFF >> (2'd3 - modeA[1:0]);
  assign txByte  = txHold;
  assign txValid = holdFull;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(RX_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeA <= '0; modeB <= '0; clkSel <= '0; auxCtrl <= '0;
      imr <= '0; vecReg <= VEC_RESET;
    end else begin
      if (stb.wrModeA) modeA <= wdata;
      if (stb.wrModeB) modeB <= wdata;
      if (stb.wrClk)   clkSel <= wdata;
      if (stb.wrAux)   auxCtrl <= wdata;
      if (stb.wrImr)   imr <= wdata;
      if (stb.wrVec)   vecReg <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEn <= 1'b0; rdPtr <= '0; wrPtr <= '0; rxCount <= '0; overrun <= 1'b0;
    end else if (stb.rxRst) begin
      rxEn <= 1'b0; rdPtr <= '0; wrPtr <= '0; rxCount <= '0; overrun <= 1'b0;
    end else begin
      if (stb.rxEnClr)      rxEn <= 1'b0;
      else if (stb.rxEnSet) rxEn <= 1'b1;
      if (rxValid && rxEn && rxFull) overrun <= 1'b1;
      if (push)  wrPtr <= nextPtr(wrPtr);
      if (doPop) rdPtr <= nextPtr(rdPtr);
      if (push && !doPop)      rxCount <= rxCount + 1'b1;
      else if (doPop && !push) rxCount <= rxCount - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) rxMem[wrPtr] <= rxByte & widthMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.txRst) begin
      txEn <= 1'b0; holdFull <= 1'b0; txHold <= '0;
    end else begin
      if (stb.txEnClr)      txEn <= 1'b0;
      else if (stb.txEnSet) txEn <= 1'b1;
      if (txLoad) begin
        holdFull <= 1'b1;
        txHold <= wdata;
      end else if (holdFull && txFree) begin
        holdFull <= 1'b0;
      end
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_MODEA: rdata = modeA;
      SEL_MODEB: rdata = modeB;
      SEL_STAT:  rdata = status;
      SEL_RX:    rdata = rxReady ? rxMem[rdPtr] : '0;
      SEL_AUX:   rdata = auxCtrl;
      SEL_ISR:   rdata = isr;
      SEL_VEC:   rdata = vecReg;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/sio_regfront.sv
module sio_regfront
  import sio_pkg::*;
#(
  parameter int                ADDR_W    = 5,
  parameter int                RX_DEPTH  = 4,
  parameter logic [BYTE_W-1:0] VEC_RESET = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              iack,
  output logic              irq,
  input  logic [7:0]        rxByte,
  input  logic              rxValid,
  output logic [7:0]        txByte,
  output logic              txValid,
  input  logic              txFree,
  output logic [7:0]        clkSel,
  output logic [7:0]        auxCtrl,
  output logic [7:0]        modeA,
  output logic [7:0]        modeB
);
  strobe_t stb;

  sio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .iack(iack),
    .addr(addr), .wdata(wdata), .stb(stb)
  );

  sio_datapath #(.RX_DEPTH(RX_DEPTH), .VEC_RESET(VEC_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(wdata),
    .rxByte(rxByte), .rxValid(rxValid), .txFree(txFree),
    .rdata(rdata), .txByte(txByte), .txValid(txValid), .irq(irq),
    .clkSel(clkSel), .auxCtrl(auxCtrl), .modeA(modeA), .modeB(modeB)
  );
endmodule

// File: rtl/sio_regfront_chk.sv
module sio_regfront_chk #(
  parameter int ADDR_W   = 5,
  parameter int RX_DEPTH = 4,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cs,
  input logic              rd,
  input logic              wr,
  input logic              iack,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              irq,
  input logic              rxValid,
  input logic              txValid,
  input logic              txFree,
  input logic [7:0]        txByte,
  input logic [CNT_W-1:0]  rxCount,
  input logic              overrun,
  input logic              rxEn,
  input logic [7:0]        imr,
  input logic [7:0]        vecReg
);
  logic cmdWr, rxRstCmd, txRstCmd, popCmd;
  assign cmdWr    = cs && wr && !iack && (addr == ADDR_W'(4));
  assign rxRstCmd = cmdWr && (wdata[7:4] == 4'h2);
  assign txRstCmd = cmdWr && (wdata[7:4] == 4'h3);
  assign popCmd   = cs && rd && !iack && (addr == ADDR_W'(6));

  p_depth_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(RX_DEPTH));

  p_push_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn && rxValid && (rxCount < CNT_W'(RX_DEPTH)) && !popCmd && !rxRstCmd)
      |=> (rxCount == $past(rxCount) + 1'b1));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !rxRstCmd) |=> overrun);

  p_rx_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn && !popCmd && !rxRstCmd) |=> $stable(rxCount));

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txFree && !txRstCmd) |=> (txValid && $stable(txByte)));

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    (imr == 8'h00) |-> !irq);

  p_iack_vec_r11: assert property (@(posedge clk) disable iff (!rstN)
    iack |-> (rdata == vecReg));
endmodule

bind sio_regfront sio_regfront_chk #(.ADDR_W(ADDR_W), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .iack(iack),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
  .rxValid(rxValid), .txValid(txValid), .txFree(txFree), .txByte(txByte),
  .rxCount(u_dp.rxCount), .overrun(u_dp.overrun), .rxEn(u_dp.rxEn),
  .imr(u_dp.imr), .vecReg(u_dp.vecReg)
);

// File: tb/sio_regfront_bench.sv
module sio_regfront_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 0, rd = 0, wr = 0, iack = 0, rxValid = 0, txFree = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rxByte = '0;
  logic [7:0] rdata, txByte, clkSel, auxCtrl, modeA, modeB;
  logic irq, txValid;
  int nChecks = 0, nErr = 0;
  logic [7:0] got;

  always #5 clk = ~clk;

  sio_regfront u_sio_regfront (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .iack(iack), .irq(irq),
    .rxByte(rxByte), .rxValid(rxValid), .txByte(txByte), .txValid(txValid),
    .txFree(txFree), .clkSel(clkSel), .auxCtrl(auxCtrl), .modeA(modeA), .modeB(modeB)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk); rxValid = 1; rxByte = b;
    @(negedge clk); rxValid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    chk("R1 idle rdata", rdata, 8'h00);
    chk("R9 reset txValid", {7'b0, txValid}, 8'h00);
    busRd(5'd2, got); chk("R6 reset status", got, 8'h00);
    busRd(5'd24, got); chk("R11 reset vector", got, 8'h0F);

    // R1 split offsets
    busWr(5'd2, 8'hBB);
    chk("R1 clkSel", clkSel, 8'hBB);
    busRd(5'd2, got); chk("R1 offset2 reads status", got, 8'h00);
    busWr(5'd8, 8'h70);
    busRd(5'd8, got); chk("R1 aux readback", got, 8'h70);

    // R2 mode pointer
    busWr(5'd4, 8'h10);
    busWr(5'd0, 8'h13); busWr(5'd0, 8'h07);
    chk("R2 modeA", modeA, 8'h13); chk("R2 modeB", modeB, 8'h07);
    busWr(5'd0, 8'h55);
    chk("R2 third write to B", modeB, 8'h55); chk("R2 A kept", modeA, 8'h13);
    busRd(5'd0, got); chk("R2 read via pointer B", got, 8'h55);
    busWr(5'd4, 8'h10);
    busRd(5'd0, got); chk("R2 read after ptr reset", got, 8'h13);

    // R5 receiver disabled
    rxPush(8'hAB);
    busRd(5'd2, got); chk("R5 disabled rx ignores", got, 8'h00);

    // R4 enable both
    busWr(5'd4, 8'h05);
    busRd(5'd2, got); chk("R4 enable -> tx ready", got, 8'h04);

    // R3 width sweep
    for (int code = 0; code < 4; code++) begin
      busWr(5'd4, 8'h10);
      busWr(5'd0, 8'(code));
      for (int p = 0; p < 4; p++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'hFF : (p == 1) ? 8'hA5 : (p == 2) ? 8'h3C : 8'hE1;
        rxPush(pat);
        busRd(5'd6, got);
        chk("R3 width mask", got, pat & 8'((9'd1 << (5 + code)) - 9'd1));
      end
    end

    // R7 fill, R8 overrun
    for (int k = 1; k <= 4; k++) begin
      rxPush(8'(8'h10 + k));
      busRd(5'd2, got);
      chk("R6 R7 fill status", got, 8'h05 | ((k == 4) ? 8'h02 : 8'h00));
    end
    rxPush(8'h99);
    busRd(5'd2, got); chk("R8 overrun status", got, 8'h17);
    for (int k = 1; k <= 4; k++) begin
      busRd(5'd6, got); chk("R7 fifo order", got, 8'(8'h10 + k));
    end
    busRd(5'd2, got); chk("R8 overrun sticky", got, 8'h14);
    busWr(5'd4, 8'h20);
    busRd(5'd2, got); chk("R8 rx reset clears", got, 8'h04);
    rxPush(8'h77);
    busRd(5'd2, got); chk("R8 rx reset disables", got, 8'h04);
    busWr(5'd4, 8'h01);
    rxPush(8'h77);
    busRd(5'd6, got); chk("R4 rx re-enabled data", got, 8'h77);

    // R9 transmit
    busWr(5'd6, 8'h41);
    chk("R9 txValid", {7'b0, txValid}, 8'h01); chk("R9 txByte", txByte, 8'h41);
    busRd(5'd2, got); chk("R6 tx busy status", got, 8'h00);
    busWr(5'd6, 8'h42);
    chk("R9 write while full ignored", txByte, 8'h41);
    @(negedge clk); txFree = 1;
    @(negedge clk); txFree = 0;
    chk("R9 taken", {7'b0, txValid}, 8'h00);
    busWr(5'd4, 8'h30);
    busWr(5'd6, 8'h43);
    chk("R9 write while disabled ignored", {7'b0, txValid}, 8'h00);
    busWr(5'd4, 8'h04);
    busWr(5'd6, 8'h44);
    busWr(5'd4, 8'h30);
    chk("R9 tx reset drops byte", {7'b0, txValid}, 8'h00);
    busWr(5'd4, 8'h04);

    // R10 interrupts
    rxPush(8'h5A);
    chk("R10 mask zero no irq", {7'b0, irq}, 8'h00);
    busWr(5'd10, 8'h02);
    chk("R10 rx irq", {7'b0, irq}, 8'h01);
    busRd(5'd10, got); chk("R10 isr", got, 8'h03);
    busRd(5'd6, got);
    chk("R10 irq drops after pop", {7'b0, irq}, 8'h00);
    busWr(5'd10, 8'h01);
    chk("R10 tx irq", {7'b0, irq}, 8'h01);
    busWr(5'd10, 8'h00);

    // R11 vector
    busWr(5'd24, 8'h40);
    busRd(5'd24, got); chk("R11 vector rw", got, 8'h40);
    @(negedge clk); iack = 1;
    #1 chk("R11 iack drives vector", rdata, 8'h40);
    @(negedge clk); iack = 0;
    #1 chk("R1 idle rdata end", rdata, 8'h00);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule